// File: doc/BRIEF.md
# Byte-Wide Memory Bootstrap Loader

This block performs the power-on program load of a 24-bit processor from a slow external memory that is only eight bits wide. When a load request arrives, it reads 1536 bytes one after another from the external bus, starting at byte address 0xC000. It gathers each group of three bytes into one 24-bit program word and writes that word into internal program RAM. The 512 words fill RAM addresses 0x0000 to 0x01FF.

Every external read is stretched by a fixed number of wait states so that slow parts can be used. While the load runs, the block holds interrupts masked, because the region being written covers the interrupt vectors. After the last word is written, the block asks the mode controller to enter single-chip mode, with execution starting at program address zero.

A load is started in one of two ways. The reset logic pulses a start input when the sampled boot mode calls for it, or software raises a bootstrap request later to reload the program.

Top module: `byte_boot_loader`

## Requirements
- R1: After reset, and whenever no load is running, `ext_rd_o`, `ext_addr_o`, `pram_we_o`, `busy_o`, `irq_mask_o` and `mode0_req_o` are all zero.
- R2: A one-cycle pulse on `start_i` or on `sw_boot_i` while idle begins a load. The first read drives byte address 0xC000 in the cycle after the clock edge that samples the pulse.
- R3: Byte reads run through consecutive addresses from 0xC000 to 0xC5FF. Each address is held with `ext_rd_o` high for 16 cycles (one access cycle plus 15 wait states). `ext_data_i` is sampled at the end of the 16th cycle.
- R4: Three successive bytes form one word. The first byte goes to bits [7:0], the second to bits [15:8] and the third to bits [23:16].
- R5: `pram_we_o` is high for exactly one cycle per word, in the cycle right after the third byte's last read cycle. The write addresses run from 0 to 511 in order.
- R6: In the cycle after the write of word 511, `mode0_req_o` is high for one cycle. This requests single-chip mode with execution at address 0. `busy_o` is low in the cycle after that.
- R7: `busy_o` is high from the cycle after the start edge through the mode-request cycle, and low at all other times.
- R8: `irq_mask_o` is high exactly while `busy_o` is high.
- R9: A `start_i` or `sw_boot_i` pulse that arrives during a load is ignored. The read, write and request sequence goes on unchanged.
- R10: A software request after a completed load runs the full 512-word load again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load pulse from reset-release logic |
| sw_boot_i | input | 1 | Load pulse from a software bootstrap request |
| ext_data_i | input | 8 | External byte-wide memory read data |
| ext_addr_o | output | 16 | External byte address, zero when idle |
| ext_rd_o | output | 1 | External read strobe |
| pram_we_o | output | 1 | Program RAM write enable |
| pram_addr_o | output | 16 | Program RAM word address |
| pram_data_o | output | 24 | Program RAM write data |
| busy_o | output | 1 | Load in progress |
| irq_mask_o | output | 1 | Interrupt mask request |
| mode0_req_o | output | 1 | Request to enter single-chip mode, with execution at address 0 |

## Verification
Some properties hold on every cycle, and the assertions check these. They cover the quiet outputs while idle, a write strobe that never lasts two cycles, read addresses that stay inside the byte window, an address held steady until its wait states have expired, word addresses that stay in range, and a mode request that is always followed by the end of busy.

Other behaviour depends on the whole sequence, and only the bench's cycle-by-cycle reference can show it. This includes the low/mid/high byte order inside each word, the exact count of 16 cycles per byte, ignored requests in the middle of a load, and a complete second load triggered by software.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_READ  = 2'd1,
        LD_WRITE = 2'd2,
        LD_HAND  = 2'd3
    } ld_state_e;

    localparam int unsigned BYTES_PER_WORD = 3;
    localparam int unsigned BYTE_W         = 8;
    localparam int unsigned PWORD_W        = BYTES_PER_WORD * BYTE_W;

endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
    parameter int unsigned WAIT_STATES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic en_i,
    output logic done_o
);
    localparam int unsigned CNT_W = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = CNT_W'(WAIT_STATES);
        end else if (en_i && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done_o = (tmr_q.cnt == '0);

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tmr_q.cnt) <= WAIT_STATES); // R3

    AST_WAIT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && !done_o) |=> (32'(tmr_q.cnt) < WAIT_STATES)); // R3
endmodule

// File: rtl/boot_byte_packer.sv
module boot_byte_packer
    import boot_ld_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_i,
    input  logic [1:0]         lane_i,
    input  logic [BYTE_W-1:0]  byte_i,
    output logic [PWORD_W-1:0] word_o
);
    typedef struct packed {
        logic [BYTES_PER_WORD-1:0][BYTE_W-1:0] lane;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        for (int i = 0; i < int'(BYTES_PER_WORD); i++) begin
            if (cap_i && (32'(lane_i) == i)) pk_d.lane[i] = byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    for (genvar g = 0; g < int'(BYTES_PER_WORD); g++) begin : g_lane
        assign word_o[g*BYTE_W +: BYTE_W] = pk_q.lane[g];
    end

    AST_LANE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |-> (32'(lane_i) < BYTES_PER_WORD)); // R4

    AST_LANE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && lane_i == 2'd0) |=> (word_o[BYTE_W-1:0] == $past(byte_i))); // R4
endmodule

// File: rtl/byte_boot_loader.sv
module byte_boot_loader
    import boot_ld_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned PADDR_W     = 16,
    parameter int unsigned BASE_ADDR   = 16'hC000,
    parameter int unsigned NUM_WORDS   = 512,
    parameter int unsigned WAIT_STATES = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               sw_boot_i,
    input  logic [7:0]         ext_data_i,
    output logic [ADDR_W-1:0]  ext_addr_o,
    output logic               ext_rd_o,
    output logic               pram_we_o,
    output logic [PADDR_W-1:0] pram_addr_o,
    output logic [23:0]        pram_data_o,
    output logic               busy_o,
    output logic               irq_mask_o,
    output logic               mode0_req_o
);
    localparam int unsigned ADDR_END  = BASE_ADDR + BYTES_PER_WORD * NUM_WORDS;
    localparam logic [PADDR_W-1:0] LAST_WORD = PADDR_W'(NUM_WORDS - 1);
    localparam logic [1:0] LAST_LANE = 2'(BYTES_PER_WORD - 1);

    typedef struct packed {
        ld_state_e          st;
        logic [ADDR_W-1:0]  baddr;
        logic [PADDR_W-1:0] word;
        logic [1:0]         lane;
    } ld_t;

    ld_t  ld_d, ld_q;
    logic tmr_load, tmr_done, cap;

    boot_wait_timer #(.WAIT_STATES(WAIT_STATES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .en_i   (ld_q.st == LD_READ),
        .done_o (tmr_done)
    );

    boot_byte_packer u_packer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .lane_i (ld_q.lane),
        .byte_i (ext_data_i),
        .word_o (pram_data_o)
    );

    always_comb begin
        ld_d     = ld_q;
        tmr_load = 1'b0;
        cap      = 1'b0;
        unique case (ld_q.st)
            LD_IDLE: begin
                if (start_i || sw_boot_i) begin
                    ld_d.st    = LD_READ;
                    ld_d.baddr = ADDR_W'(BASE_ADDR);
                    ld_d.word  = '0;
                    ld_d.lane  = '0;
                    tmr_load   = 1'b1;
                end
            end
            LD_READ: begin
                if (tmr_done) begin
                    cap = 1'b1;
                    if (ld_q.lane == LAST_LANE) begin
                        ld_d.st   = LD_WRITE;
                        ld_d.lane = '0;
                    end else begin
                        ld_d.lane  = ld_q.lane + 1'b1;
                        ld_d.baddr = ld_q.baddr + 1'b1;
                        tmr_load   = 1'b1;
                    end
                end
            end
            LD_WRITE: begin
                if (ld_q.word == LAST_WORD) begin
                    ld_d.st = LD_HAND;
                end else begin
                    ld_d.st    = LD_READ;
                    ld_d.word  = ld_q.word + 1'b1;
                    ld_d.baddr = ld_q.baddr + 1'b1;
                    tmr_load   = 1'b1;
                end
            end
            LD_HAND: begin
                ld_d.st = LD_IDLE;
            end
            default: ld_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q <= '{st: LD_IDLE, baddr: '0, word: '0, lane: '0};
        end else begin
            ld_q <= ld_d;
        end
    end

    assign ext_rd_o    = (ld_q.st == LD_READ);
    assign ext_addr_o  = ext_rd_o ? ld_q.baddr : '0;
    assign pram_we_o   = (ld_q.st == LD_WRITE);
    assign pram_addr_o = ld_q.word;
    assign mode0_req_o = (ld_q.st == LD_HAND);
    assign busy_o      = (ld_q.st != LD_IDLE);
    assign irq_mask_o  = busy_o;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ext_rd_o && ext_addr_o == '0 && !pram_we_o && !mode0_req_o)); // R1

    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rd_o |-> (32'(ext_addr_o) >= BASE_ADDR && 32'(ext_addr_o) < ADDR_END)); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd_o && !tmr_done) |=> (ext_rd_o && $stable(ext_addr_o))); // R3

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pram_we_o |=> !pram_we_o); // R5

    AST_WE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pram_we_o |-> (32'(pram_addr_o) < NUM_WORDS)); // R5

    AST_REQ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        mode0_req_o |=> (!busy_o && !mode0_req_o)); // R6

    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mode0_req_o) |=> irq_mask_o); // R8
endmodule

// File: tb/byte_boot_loader_test.sv
module byte_boot_loader_test;
    localparam int PERIOD = 10;
    localparam int BASE   = 16'hC000;
    localparam int WORDS  = 512;
    localparam int HOLD   = 16;

    typedef struct packed {
        bit        rd;
        bit [15:0] addr;
        bit        we;
        bit [15:0] pa;
        bit [23:0] pd;
        bit        req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sw_boot_i = 1'b0;
    logic [7:0]  ext_data_i;
    logic [15:0] ext_addr_o;
    logic        ext_rd_o, pram_we_o, busy_o, irq_mask_o, mode0_req_o;
    logic [15:0] pram_addr_o;
    logic [23:0] pram_data_o;

    int   total = 0;
    int   bad = 0;
    int   writes_seen = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign ext_data_i = mem_byte(ext_addr_o);

    byte_boot_loader uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sw_boot_i(sw_boot_i),
        .ext_data_i(ext_data_i), .ext_addr_o(ext_addr_o), .ext_rd_o(ext_rd_o),
        .pram_we_o(pram_we_o), .pram_addr_o(pram_addr_o), .pram_data_o(pram_data_o),
        .busy_o(busy_o), .irq_mask_o(irq_mask_o), .mode0_req_o(mode0_req_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_load();
        for (int w = 0; w < WORDS; w++) begin
            logic [23:0] word = '0;
            for (int b = 0; b < 3; b++) begin
                logic [15:0] a = 16'(BASE + 3*w + b);
                word[8*b +: 8] = mem_byte(a);
                for (int c = 0; c < HOLD; c++) q.push_back('{1'b1, a, 1'b0, 16'h0, 24'h0, 1'b0});
            end
            q.push_back('{1'b0, 16'h0, 1'b1, 16'(w), word, 1'b0});
        end
        q.push_back('{1'b0, 16'h0, 1'b0, 16'h0, 24'h0, 1'b1});
    endtask

    // One cycle: sample at the falling edge and compare against the model.
    task automatic tick(input string rd_tag);
        exp_t e;
        bit   eb;
        @(negedge clk);
        eb = (q.size() != 0);
        e  = eb ? q.pop_front() : '0;
        check(ext_rd_o == e.rd && ext_addr_o == e.addr, rd_tag,
              {ext_rd_o, ext_addr_o}, {e.rd, e.addr});
        check(pram_we_o == e.we, "R5 we", pram_we_o, e.we);
        if (e.we) begin
            writes_seen++;
            check(pram_addr_o == e.pa, "R5 word address", pram_addr_o, e.pa);
            check(pram_data_o == e.pd, "R4 packed word", pram_data_o, e.pd);
        end
        check(mode0_req_o == e.req, "R6 mode request", mode0_req_o, e.req);
        check(busy_o == eb, "R7 busy", busy_o, eb);
        check(irq_mask_o == eb, "R8 irq mask", irq_mask_o, eb);
    endtask

    task automatic run_until_idle(input int extra);
        while (q.size() != 0) tick("R3 read");
        for (int i = 0; i < extra; i++) tick("R1 idle");
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check(!ext_rd_o && ext_addr_o == 0 && !pram_we_o && !busy_o && !mode0_req_o,
                  "R1 reset state", {ext_rd_o, busy_o, ext_addr_o}, 0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) tick("R1 idle");

        // Load from reset-release start pulse
        start_i = 1'b1;
        push_load();
        tick("R1 idle");
        start_i = 1'b0;
        tick("R2 first address");
        for (int i = 0; i < 40; i++) tick("R3 read");
        // Requests during a load are ignored
        sw_boot_i = 1'b1;
        tick("R3 read");
        sw_boot_i = 1'b0;
        start_i = 1'b1;
        tick("R9 ignored request");
        start_i = 1'b0;
        for (int i = 0; i < 2000; i++) tick("R9 sequence unchanged");
        run_until_idle(5);
        check(writes_seen == WORDS, "R5 write count", writes_seen, WORDS);

        // Software-initiated reload
        writes_seen = 0;
        sw_boot_i = 1'b1;
        push_load();
        tick("R1 idle");
        sw_boot_i = 1'b0;
        tick("R10 reload first address");
        run_until_idle(5);
        check(writes_seen == WORDS, "R10 reload write count", writes_seen, WORDS);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule